// File: doc/BRIEF.md
# Bus-Master Access Ready Responder

This block decides when the bridge drives the shared channel-ready line of an ISA-style expansion bus, and what value it drives. It is used while an external bus master owns the bus and issues an I/O read or write strobe. If the access decodes to a target inside the bridge, the responder pulls the ready line low as soon as it sees the strobe fall, which stretches the cycle. When the internal side reports that read data is valid or that write data has been captured, the responder drives the line high for a fixed release window and then removes its output enable so that the bus pull-up holds the line.

The responder never drives the line when the master is talking to another card on the bus. It also never drives it while the bridge is itself the bus owner, because the line is an input to the bridge at those times. The release window is given in picoseconds together with the clock period, and the block rounds it up to a whole number of cycles. A strobe that is already low when reset ends, or that stays low after the window has closed, does not start a new access. A new access starts only after the strobe has gone high and then falls again.

Top module: `isa_rdy_responder`

## Requirements
- R1: While `rst_n` is low, and after reset until an internal access is decoded, `rdy_oe` is 0.
- R2: When the master owns the bus (`bridge_owns_bus`=0) and a command strobe (`cmd_rd_n` or `cmd_wr_n`, active low) falls with `int_hit`=1, then from the next cycle `rdy_oe`=1 and `rdy_out`=0 until `data_done` is seen.
- R3: `data_done`=1, sampled while the line is held low, makes `rdy_out`=1 with `rdy_oe`=1 from the next cycle for exactly HOLD_CYCLES cycles. After that `rdy_oe` returns to 0.
- R4: If `int_hit` is 0 when the strobe falls, `rdy_oe` stays 0 for that whole command.
- R5: In any cycle where `bridge_owns_bus`=1, `rdy_oe` is 0 in that same cycle. If this happens during an access, the responder abandons that command.
- R6: If both strobes are sampled high while the responder is driving, `rdy_oe` is 0 from the next cycle.
- R7: After the release window, or after an abandoned access, `rdy_oe` stays 0 while the strobe remains low, even if `data_done` is asserted again. A new access needs the strobe to be sampled high first.
- R8: `int_hit` is sampled only in the cycle the strobe falls. Raising it later during the same command does not start driving.
- R9: A strobe that is already low when `rst_n` rises is not taken as a falling edge.
- R10: HOLD_CYCLES = ceil(RELEASE_PS / CLK_PERIOD_PS), with a minimum of 1. The defaults (70000 ps, 30000 ps) give 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-side clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_rd_n | input | 1 | I/O read strobe, active low, synchronous to clk |
| cmd_wr_n | input | 1 | I/O write strobe, active low, synchronous to clk |
| bridge_owns_bus | input | 1 | 1 while the bridge itself owns the bus |
| int_hit | input | 1 | Decode says the address targets a resource inside the bridge |
| data_done | input | 1 | Read data valid or write data latched on the internal side |
| rdy_out | output | 1 | Value to drive onto the ready line |
| rdy_oe | output | 1 | Output enable for the tri-state ready pad |

## Verification
A strobe fall, a `data_done` pulse, or a strobe release each passes through one register, so the bench drives inputs just after a falling clock edge and checks the result at the next falling edge. The high phase is counted sample by sample: HOLD_CYCLES samples must show `rdy_out`=1, and the sample after the last one must show the enable off. `bridge_owns_bus` gates the enable without a register, so it is checked one time step after it is driven, inside the same cycle. The sweeps cover every `data_done` delay from 0 to 5 cycles on both strobes, and an early release at every point of an access.

// File: rtl/isa_rdy_pkg.sv
// Package: shared state type and window conversion for the ready responder.
// Assumes all times are given in picoseconds.
package isa_rdy_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // not driving, armed for a new strobe fall
        ST_LOW   = 2'd1,   // driving not-ready while internal side works
        ST_HIGH  = 2'd2,   // driving ready for the release window
        ST_SPENT = 2'd3    // floated, waiting for the strobe to go high
    } rdy_state_e;

    // Rounds a time window up to whole clock cycles, never less than one.
    function automatic int unsigned window_cycles(input int unsigned win_ps,
                                                  input int unsigned clk_ps);
        int unsigned c;
        c = (win_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/isa_rdy_cmd_edge.sv
// Module: detects a new command from the two active-low strobes.
// Assumes the strobes are already synchronous to clk. The history register
// resets to "active", so a strobe held low through reset is not an edge.
module isa_rdy_cmd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic cmd_active,
    output logic cmd_fall
);

    logic active_q;

    // Combine both strobes into one command-present level.
    always_comb begin
        cmd_active = ~rd_n | ~wr_n;
        cmd_fall   = cmd_active & ~active_q;
    end

    // Keep last cycle's command level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) active_q <= 1'b1;
        else        active_q <= cmd_active;
    end

endmodule

// File: rtl/isa_rdy_window.sv
// Module: down-counter that times the ready-high release window.
// Assumes load and dec are never asserted together.
module isa_rdy_window #(
    parameter int unsigned HOLD = 3,
    localparam int unsigned CW = (HOLD < 2) ? 1 : $clog2(HOLD)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic expired
);

    localparam logic [CW-1:0] START = CW'(HOLD - 1);

    logic [CW-1:0] cnt_q;

    // Load on entry to the window, count down while in it.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (load)            cnt_q <= START;
        else if (dec && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    // Flag the last cycle of the window.
    always_comb expired = (cnt_q == '0);

endmodule

// File: rtl/isa_rdy_fsm.sv
// Module: access sequencer that decides when to hold, release and float the
// ready line. Assumes cmd_fall and cmd_active come from isa_rdy_cmd_edge.
module isa_rdy_fsm
    import isa_rdy_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_fall,
    input  logic cmd_active,
    input  logic bridge_owns,
    input  logic hit,
    input  logic done,
    input  logic win_expired,
    output logic win_load,
    output logic win_dec,
    output logic drive_en,
    output logic drive_val
);

    rdy_state_e state_q, state_d;

    // Next-state selection and window control.
    always_comb begin
        state_d  = state_q;
        win_load = 1'b0;
        win_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_fall && hit && !bridge_owns) state_d = ST_LOW;
            end
            ST_LOW: begin
                if (!cmd_active)     state_d = ST_IDLE;
                else if (bridge_owns) state_d = ST_SPENT;
                else if (done) begin
                    state_d  = ST_HIGH;
                    win_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!cmd_active)      state_d = ST_IDLE;
                else if (bridge_owns || win_expired) state_d = ST_SPENT;
                else                  win_dec = 1'b1;
            end
            ST_SPENT: begin
                if (!cmd_active) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered pad controls decoded from state.
    always_comb begin
        drive_en  = (state_q == ST_LOW) || (state_q == ST_HIGH);
        drive_val = (state_q == ST_HIGH);
    end

endmodule

// File: rtl/isa_rdy_responder.sv
// Module: top of the ready-line responder for external-master accesses to
// bridge-internal targets. Assumes strobes are synchronous to clk and that
// the pad combines rdy_out/rdy_oe into a tri-state driver.
module isa_rdy_responder #(
    parameter int unsigned CLK_PERIOD_PS = 30000,
    parameter int unsigned RELEASE_PS    = 70000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_rd_n,
    input  logic cmd_wr_n,
    input  logic bridge_owns_bus,
    input  logic int_hit,
    input  logic data_done,
    output logic rdy_out,
    output logic rdy_oe
);

    localparam int unsigned HOLD_CYCLES =
        isa_rdy_pkg::window_cycles(RELEASE_PS, CLK_PERIOD_PS);

    logic cmd_active, cmd_fall;
    logic win_load, win_dec, win_expired;
    logic drive_en, drive_val;

    isa_rdy_cmd_edge u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_n       (cmd_rd_n),
        .wr_n       (cmd_wr_n),
        .cmd_active (cmd_active),
        .cmd_fall   (cmd_fall)
    );

    isa_rdy_window #(.HOLD(HOLD_CYCLES)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (win_load),
        .dec     (win_dec),
        .expired (win_expired)
    );

    isa_rdy_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_fall    (cmd_fall),
        .cmd_active  (cmd_active),
        .bridge_owns (bridge_owns_bus),
        .hit         (int_hit),
        .done        (data_done),
        .win_expired (win_expired),
        .win_load    (win_load),
        .win_dec     (win_dec),
        .drive_en    (drive_en),
        .drive_val   (drive_val)
    );

    // Pad controls: ownership by the bridge overrides the enable at once.
    always_comb begin
        rdy_oe  = drive_en & ~bridge_owns_bus & rst_n;
        rdy_out = drive_val;
    end

endmodule

// File: rtl/isa_rdy_responder_chk.sv
// Module: property checker bound to isa_rdy_responder. Observes ports only.
module isa_rdy_responder_chk #(
    parameter int unsigned HOLD = 3
) (
    input logic clk,
    input logic rst_n,
    input logic cmd_rd_n,
    input logic cmd_wr_n,
    input logic bridge_owns_bus,
    input logic rdy_out,
    input logic rdy_oe
);

    localparam int unsigned HW = $clog2(HOLD + 2);

    logic [HW-1:0] hi_run_q;
    logic          seen_q;

    // Note that at least one clock edge has passed.
    always_ff @(posedge clk) seen_q <= 1'b1;

    // Length of the current run of driven-high cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                hi_run_q <= '0;
        else if (rdy_oe && rdy_out) begin
            if (hi_run_q <= HW'(HOLD)) hi_run_q <= hi_run_q + 1'b1;
        end
        else                       hi_run_q <= '0;
    end

    // R1: no drive while reset is held.
    assert_no_drive_in_reset_R1: assert property (@(posedge clk)
        (seen_q === 1'b1 && !rst_n) |-> !rdy_oe);

    // R2: every drive period opens at the not-ready level.
    assert_drive_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_oe) |-> !rdy_out);

    // R3: the high window never runs past HOLD cycles.
    assert_window_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hi_run_q <= HW'(HOLD));

    // R3: leaving the high level always floats the line.
    assert_high_ends_float_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_out) |-> !rdy_oe);

    // R5: never drive while the bridge owns the bus.
    assert_owner_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bridge_owns_bus |-> !rdy_oe);

    // R6: a released strobe ends driving on the next cycle.
    assert_release_floats_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_rd_n && cmd_wr_n) |=> !rdy_oe);

endmodule

bind isa_rdy_responder isa_rdy_responder_chk #(.HOLD(HOLD_CYCLES)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_rd_n        (cmd_rd_n),
    .cmd_wr_n        (cmd_wr_n),
    .bridge_owns_bus (bridge_owns_bus),
    .rdy_out         (rdy_out),
    .rdy_oe          (rdy_oe)
);

// File: tb/isa_rdy_responder_tb.sv
module isa_rdy_responder_tb;

    localparam int unsigned CLK_PS = 20000;
    localparam int unsigned REL_PS = 70000;
    localparam int HOLD = (REL_PS + CLK_PS - 1) / CLK_PS;   // R10: 4 here

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_rd_n = 1'b1, cmd_wr_n = 1'b1;
    logic bridge_owns_bus = 1'b0, int_hit = 1'b0, data_done = 1'b0;
    logic rdy_out, rdy_oe;
    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #10ns clk = ~clk;

    isa_rdy_responder #(.CLK_PERIOD_PS(CLK_PS), .RELEASE_PS(REL_PS)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_rd_n(cmd_rd_n), .cmd_wr_n(cmd_wr_n),
        .bridge_owns_bus(bridge_owns_bus), .int_hit(int_hit),
        .data_done(data_done), .rdy_out(rdy_out), .rdy_oe(rdy_oe));

    task automatic chk(input string req, input logic exp_oe, input logic exp_out,
                       input bit check_out);
        total++;
        if (rdy_oe !== exp_oe || (check_out && rdy_out !== exp_out)) begin
            bad++;
            $display("FAIL %s t=%0t oe=%b out=%b expected oe=%b out=%b",
                     req, $time, rdy_oe, rdy_out, exp_oe, exp_out);
        end
    endtask

    task automatic strobe(input bit wr, input logic lvl);
        if (wr) cmd_wr_n = lvl; else cmd_rd_n = lvl;
    endtask

    task automatic release_cmd();
        cmd_rd_n = 1'b1; cmd_wr_n = 1'b1; int_hit = 1'b0; data_done = 1'b0;
        @(negedge clk);
        chk("R6", 1'b0, 1'b0, 1'b0);
    endtask

    // Full access with data_done after d held-low samples.
    task automatic access(input bit wr, input int d);
        @(negedge clk);
        chk("R1", 1'b0, 1'b0, 1'b0);
        strobe(wr, 1'b0); int_hit = 1'b1;
        @(negedge clk);
        chk("R2", 1'b1, 1'b0, 1'b1);
        int_hit = 1'b0;
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk("R2", 1'b1, 1'b0, 1'b1);
        end
        data_done = 1'b1;
        for (int k = 0; k < HOLD; k++) begin
            @(negedge clk);
            chk("R3", 1'b1, 1'b1, 1'b1);
            data_done = 1'b0;
        end
        @(negedge clk);
        chk("R3", 1'b0, 1'b0, 1'b0);
        data_done = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R7", 1'b0, 1'b0, 1'b0);
        end
        release_cmd();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R9: strobe low and hit high through reset release
        cmd_rd_n = 1'b0; int_hit = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R1", 1'b0, 1'b0, 1'b0);
        end
        rst_n = 1'b1;
        data_done = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk("R9", 1'b0, 1'b0, 1'b0);
        end
        release_cmd();

        // R2/R3/R7 sweep over data_done delay and strobe kind
        for (int wr = 0; wr < 2; wr++)
            for (int d = 0; d < 6; d++)
                access(wr[0], d);

        // R6: early release at every point of an access
        for (int a = 1; a <= HOLD + 3; a++) begin
            @(negedge clk);
            cmd_wr_n = 1'b0; int_hit = 1'b1;
            for (int c = 0; c < a; c++) begin
                @(negedge clk);
                int_hit = 1'b0;
                data_done = (c == 1);
            end
            release_cmd();
            @(negedge clk);
            chk("R6", 1'b0, 1'b0, 1'b0);
        end

        // R4: access decoded to an external slave
        @(negedge clk);
        cmd_rd_n = 1'b0; int_hit = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk("R4", 1'b0, 1'b0, 1'b0);
            data_done = (c == 2);
        end
        // R8: hit rising later in the same command
        int_hit = 1'b1; data_done = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R8", 1'b0, 1'b0, 1'b0);
        end
        release_cmd();

        // R5: bridge ownership gates the enable in the same cycle
        @(negedge clk);
        cmd_rd_n = 1'b0; int_hit = 1'b1;
        @(negedge clk);
        chk("R2", 1'b1, 1'b0, 1'b1);
        bridge_owns_bus = 1'b1;
        #1ns;
        chk("R5", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R5", 1'b0, 1'b0, 1'b0);
        bridge_owns_bus = 1'b0; data_done = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R7", 1'b0, 1'b0, 1'b0);
        end
        release_cmd();

        // R5: strobe fall while the bridge owns the bus is ignored
        @(negedge clk);
        bridge_owns_bus = 1'b1; cmd_wr_n = 1'b0; int_hit = 1'b1;
        @(negedge clk);
        bridge_owns_bus = 1'b0;
        #1ns;
        chk("R5", 1'b0, 1'b0, 1'b0);
        release_cmd();

        // R10: one more access confirms the computed window after all cases
        access(1'b0, 1);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule